// File: doc/BRIEF.md
# Six-Channel Pulse-Width DAC Bank

This block drives six pulse-width-modulated outputs whose averaged level serves as a coarse analog voltage once filtered off-chip. Each output has its own 8-bit duty code in a small register window. One control register holds two bits shared by all channels. The first bit selects one of two base rates (nominally 47 kHz or 94 kHz), both derived from the system clock by one prescaler. The second bit selects a period of 256 or 253 steps.

All channels share one period counter and switch together. A duty write lands in a holding register at once and is copied to the compare stage only when the period wraps, so no output shows a shortened or stretched pulse. In the 253-step mode the three highest codes hold the output high for the whole period. In the 256-step mode even the highest code leaves one low step in every period.

Top module: `pwm_dac_bank`

## Requirements
- R1: Bus offsets 0 to 5 hold the duty codes of channels 0 to 5. A write with bus_sel=1 and bus_we=1 stores bus_wdata, and bus_rdata (combinational on bus_addr) returns the last value written, even before it is in use.
- R2: After reset every duty code reads 0x80 and the control register reads 0x00 (slow rate, 256 steps). All outputs start high at the first step of a period.
- R3: Within a period, an output is high exactly while the step number is below its active duty code. In 256-step mode, code D gives D high steps out of 256.
- R4: With control bit 1 set (253 steps, step numbers 0 to 252), codes 0xFD, 0xFE and 0xFF keep the output constantly high. Lower codes give D high steps out of 253.
- R5: In 256-step mode, code 0xFF leaves the output low for exactly one step in every period.
- R6: Code 0x00 keeps the output constantly low in both modes.
- R7: Offset 6 is the control register: bit 0 selects the fast rate and bit 1 selects 253 steps. One step lasts DIV = floor(SYS_CLK_HZ / (BASE_PWM_HZ * 256)) clock cycles at the slow rate and DIV/2 at the fast rate (4 and 2 with the defaults).
- R8: Duty and control writes take effect only at the next period start, and all six outputs rise only at a period start.
- R9: Offset 7 reads as 0x00, and a write to it changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | AW (3) | Register offset |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (6) | Modulated outputs, one bit per channel |

## Verification
Read data is due in the same cycle as the address, and the bench samples it one time step after driving the address at the falling edge. A new duty code shows on the outputs only after the running period ends. This takes up to 256 steps of DIV cycles, plus a further period if the control register changed as well. The bench therefore waits more than two of the longest periods before it measures. It then counts high samples at falling edges over exactly one period length, a count that does not depend on phase. The deferred-update check finds the period end from the observed falling edge of a 0xFF channel. It then counts the DIV cycles of the final step to place its write inside a known period.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    // Global control bits shared by all channels (bit 0 = fast, bit 1 = short period)
    typedef struct packed {
        logic mode_short;
        logic fast;
    } pwm_ctrl_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int DIV_FAST = (DIV_SLOW > 1) ? DIV_SLOW / 2 : 1;
    localparam int CW       = $clog2(DIV_SLOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [CW-1:0] limit;

    always_comb begin
        s_d   = s_q;
        limit = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
        tick  = (s_q.cnt >= limit);
        if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_short,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    localparam logic [DW-1:0] LAST_FULL  = DW'((2 ** DW) - 1);
    localparam logic [DW-1:0] LAST_SHORT = DW'((2 ** DW) - 4);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t s_d, s_q;
    logic [DW-1:0] last;

    always_comb begin
        s_d  = s_q;
        last = mode_short ? LAST_SHORT : LAST_FULL;
        wrap = tick && (s_q.cnt >= last);
        if (wrap) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

endmodule

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs
    import pwm_dac_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DW     = 8,
    parameter int AW     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic                     load,
    output logic [NUM_CH-1:0][DW-1:0] duty_act,
    output pwm_ctrl_t                ctrl_act
);
    localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);
    localparam logic [AW-1:0] CTRL_OFS = AW'(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] duty;
        logic [NUM_CH-1:0][DW-1:0] duty_act;
        pwm_ctrl_t                 ctrl;
        pwm_ctrl_t                 ctrl_act;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bus_sel && bus_we) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == AW'(i)) begin
                    s_d.duty[i] = bus_wdata;
                end
            end
            if (bus_addr == CTRL_OFS) begin
                s_d.ctrl = pwm_ctrl_t'(bus_wdata[1:0]);
            end
        end
        if (load) begin
            s_d.duty_act = s_q.duty;
            s_d.ctrl_act = s_q.ctrl;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == AW'(i)) begin
                bus_rdata = s_q.duty[i];
            end
        end
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = {{(DW - 2){1'b0}}, s_q.ctrl};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.duty     <= {NUM_CH{MID_CODE}};
            s_q.duty_act <= {NUM_CH{MID_CODE}};
            s_q.ctrl     <= '0;
            s_q.ctrl_act <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign duty_act = s_q.duty_act;
    assign ctrl_act = s_q.ctrl_act;

endmodule

// File: rtl/pwm_cmp_lane.sv
module pwm_cmp_lane #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] code,
    output logic          level
);
    always_comb begin
        level = (step < code);
    end

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
    import pwm_dac_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int DW          = 8,
    parameter int AW          = 3,
    parameter int SYS_CLK_HZ  = 50_000_000,
    parameter int BASE_PWM_HZ = 47_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int RAW_DIV  = SYS_CLK_HZ / (BASE_PWM_HZ * (2 ** DW));
    localparam int DIV_SLOW = (RAW_DIV > 0) ? RAW_DIV : 1;

    logic                      step_tick;
    logic                      period_wrap;
    logic [DW-1:0]             period_cnt;
    logic [NUM_CH-1:0][DW-1:0] duty_act;
    pwm_ctrl_t                 ctrl_act;

    pwm_dac_regs #(
        .NUM_CH (NUM_CH),
        .DW     (DW),
        .AW     (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load      (period_wrap),
        .duty_act  (duty_act),
        .ctrl_act  (ctrl_act)
    );

    pwm_prescaler #(
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .fast  (ctrl_act.fast),
        .tick  (step_tick)
    );

    pwm_period_ctr #(
        .DW (DW)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (step_tick),
        .mode_short (ctrl_act.mode_short),
        .cnt        (period_cnt),
        .wrap       (period_wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        pwm_cmp_lane #(
            .DW (DW)
        ) u_lane (
            .step  (period_cnt),
            .code  (duty_act[g]),
            .level (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int DW     = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [DW-1:0]             cnt,
    input logic                      wrap,
    input logic                      mode_short,
    input logic [NUM_CH-1:0][DW-1:0] duty_act,
    input logic [NUM_CH-1:0]         pwm_out
);
    localparam logic [DW-1:0] LAST_SHORT = DW'((2 ** DW) - 4);
    localparam logic [DW-1:0] SAT_CODE   = DW'((2 ** DW) - 3);
    localparam logic [DW-1:0] LAST_FULL  = DW'((2 ** DW) - 1);

    // R4: short period never counts past its last step
    a_r4_short_range: assert property (@(posedge clk) disable iff (!rst_n)
        mode_short |-> (cnt <= LAST_SHORT));

    // R8: active codes only move at a period boundary
    a_r8_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_act));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8: outputs rise only on the first step
        a_r8_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[g]) |-> (cnt == '0));
        // R6: zero code is always low
        a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_act[g] == '0) |-> !pwm_out[g]);
        // R4: top codes saturate high in short mode
        a_r4_top_high: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_short && duty_act[g] >= SAT_CODE) |-> pwm_out[g]);
        // R5: last step of a full period is always low
        a_r5_last_low: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_short && cnt == LAST_FULL) |-> !pwm_out[g]);
    end

endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(
    .NUM_CH (NUM_CH),
    .DW     (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (period_cnt),
    .wrap       (period_wrap),
    .mode_short (ctrl_act.mode_short),
    .duty_act   (duty_act),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;
    localparam int NUM_CH = 6;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int SYS_HZ = 50_000_000;
    localparam int BASE   = 47_000;
    localparam int DIV_S  = SYS_HZ / (BASE * 256);   // R7: 4
    localparam int DIV_F  = DIV_S / 2;                // R7: 2
    localparam int SETTLE = 2200;
    localparam int NVEC   = 5;

    // {fast, short, code0..code5}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF, 8'h40},
        {1'b0, 1'b1, 8'hFC, 8'hFD, 8'hFE, 8'hFF, 8'h00, 8'h01},
        {1'b1, 1'b0, 8'hFF, 8'h7F, 8'h80, 8'h10, 8'h00, 8'hC8},
        {1'b1, 1'b1, 8'hFD, 8'hFC, 8'h02, 8'hFF, 8'h81, 8'h00},
        {1'b0, 1'b0, 8'h20, 8'h40, 8'h60, 8'hA0, 8'hC0, 8'hE0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int hi_cnt [NUM_CH];
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_dac_bank u_pwm_dac_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int addr, output logic [DW-1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        #1 data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic measure(input int len);
        for (int c = 0; c < NUM_CH; c++) hi_cnt[c] = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            for (int c = 0; c < NUM_CH; c++) if (pwm_out[c]) hi_cnt[c]++;
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(pwm_out == 6'h3F, "R2 outputs high at period start", int'(pwm_out), 63);
        for (int a = 0; a < NUM_CH; a++) begin
            bus_read(a, rd);
            chk(rd == 8'h80, "R2 duty reset value", int'(rd), 128);
        end
        bus_read(NUM_CH, rd);
        chk(rd == 8'h00, "R2 control reset value", int'(rd), 0);
        measure(256 * DIV_S);
        chk(hi_cnt[3] == 128 * DIV_S, "R2 mid-scale duty", hi_cnt[3], 128 * DIV_S);

        // R9: unused offset
        bus_write(7, 8'hA5);
        bus_read(7, rd);
        chk(rd == 8'h00, "R9 unused offset reads zero", int'(rd), 0);
        for (int a = 0; a < NUM_CH; a++) begin
            bus_read(a, rd);
            chk(rd == 8'h80, "R9 write to unused offset leaves duty", int'(rd), 128);
        end
        repeat (SETTLE) @(negedge clk);
        measure(256 * DIV_S);
        chk(hi_cnt[0] == 128 * DIV_S, "R9 output unchanged", hi_cnt[0], 128 * DIV_S);

        // Table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic fast_b, short_b;
            int steps, div, plen;
            fast_b  = VEC[v][49];
            short_b = VEC[v][48];
            steps   = short_b ? 253 : 256;
            div     = fast_b ? DIV_F : DIV_S;
            plen    = steps * div;
            bus_write(NUM_CH, {6'b0, short_b, fast_b});
            for (int c = 0; c < NUM_CH; c++) begin
                logic [DW-1:0] code;
                code = VEC[v][47 - 8 * c -: 8];
                bus_write(c, code);
                bus_read(c, rd);
                chk(rd == code, "R1 readback of pending code", int'(rd), int'(code));
            end
            repeat (SETTLE) @(negedge clk);
            measure(plen);
            for (int c = 0; c < NUM_CH; c++) begin
                int code, expv;
                string tag;
                code = int'(VEC[v][47 - 8 * c -: 8]);
                expv = ((code > steps) ? steps : code) * div;
                if (code == 0)                  tag = "R6 zero code constant low";
                else if (short_b && code >= 253) tag = "R4 top code constant high";
                else if (!short_b && code == 255) tag = "R5 full code one low step";
                else if (fast_b)                 tag = "R7 fast rate duty count";
                else                             tag = "R3 duty count";
                chk(hi_cnt[c] == expv, tag, hi_cnt[c], expv);
            end
        end

        // R8: deferred update through holding register
        bus_write(NUM_CH, 8'h00);
        bus_write(0, 8'hFF);
        repeat (SETTLE) @(negedge clk);
        begin
            logic prev;
            prev = pwm_out[0];
            forever begin
                @(negedge clk);
                if (prev && !pwm_out[0]) break;
                prev = pwm_out[0];
            end
        end
        repeat (6) @(negedge clk);
        bus_write(0, 8'h00);
        chk(pwm_out[0] == 1'b1, "R8 write not applied mid-period", int'(pwm_out[0]), 1);
        measure(200 * DIV_S);
        chk(hi_cnt[0] == 200 * DIV_S, "R8 old code kept until period end",
            hi_cnt[0], 200 * DIV_S);
        repeat (80 * DIV_S) @(negedge clk);
        measure(256 * DIV_S);
        chk(hi_cnt[0] == 0, "R8 new code applied next period", hi_cnt[0], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule